// File: doc/BRIEF.md
# Packed SIMD Less-or-Equal Compare Unit

This block takes one 32-bit vector compare instruction word together with two packed source operands. It produces a lane-by-lane "less than or equal" mask: every destination lane is all ones where the first lane is at most the second lane, and all zeros elsewhere. The lanes can be 8, 16 or 32 bits of signed or unsigned integer data, or 32-bit single-precision floats. A compare-with-zero form tests each lane of one operand against zero.

The block is used as an execute-stage slice. The surrounding pipeline reads the register file and presents both operands with a valid strobe. The block captures the word and the operands on that edge and decodes the fields combinationally from the captured copy. One cycle later it returns the mask, the destination register number and a write enable. If the word does not describe a legal compare, an undefined-encoding flag is raised instead of the write enable. The block never reads or changes condition flags.

Top module: `simd_cle_unit`

## Requirements
- R1: Each destination lane is all ones when its first-operand lane is less than or equal to the matching second-operand lane, and all zeros otherwise. Lanes are independent of each other.
- R2: The register integer form is `instr[31:25]=1111001`, `instr[23]=0`, `instr[11:8]=0011`, `instr[4]=1`. Bit 24 selects unsigned (1) or signed (0) lanes. `instr[21:20]` selects the lane width: 00 is 8 bits, 01 is 16 bits, 10 is 32 bits. The first operand is `opa_in` and the second is `opb_in`.
- R3: The register float form is `instr[31:23]=111100110`, `instr[21]=0`, `instr[11:8]=1110`, `instr[4]=0`. It compares IEEE single-precision lanes of `opa_in` against `opb_in`. `instr[20]` must be 0.
- R4: The compare-with-zero form is `instr[31:23]=111100111`, `instr[21:20]=11`, `instr[17:16]=01`, `instr[11]=0`, `instr[9:7]=011`, `instr[4]=0`. It tests each lane of `opb_in` for being at most zero. Bit 10 set selects float lanes; bit 10 clear selects signed integer lanes whose width comes from `instr[19:18]`, coded as in R2.
- R5: `instr[6]=1` operates on all 128 bits. `instr[6]=0` operates on bits 63:0 only and returns zero in result bits 127:64.
- R6: In float compares, a lane in which either input is a NaN gives all zeros. +0 and -0 compare as equal, and infinities and denormals follow IEEE ordering.
- R7: The undefined flag is raised, the write enable stays low and the result is zero for any of these words:
  - a word that matches none of the three forms;
  - a lane-size code of 11;
  - the float register form with `instr[20]=1`;
  - the zero form with bit 10 set and a size code other than 10;
  - a 128-bit form (`instr[6]=1`) in which any of `instr[12]` (destination), `instr[16]` (first source, register forms only) or `instr[0]` (second source) is 1.
- R8: The write enable or the undefined flag is high only in the cycle right after a cycle in which `valid_in` was high. Exactly one of the two is high in that cycle, and both are low in every other cycle.
- R9: The destination number is `{instr[22], instr[15:12]}` for 64-bit forms. For 128-bit forms it is that value shifted right by one.
- R10: While reset is high, the write enable and the undefined flag are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | Instruction word and operands are present this cycle |
| instr_in | input | 32 | Compare instruction word |
| opa_in | input | VEC_W | First source operand (register form) |
| opb_in | input | VEC_W | Second source operand; the tested operand in the zero form |
| wr_en_o | output | 1 | Legal compare result is ready for write-back |
| undef_o | output | 1 | Captured word is not a legal compare |
| dest_o | output | 5 | Destination register number |
| result_o | output | VEC_W | Lane mask result |

## Verification
The hardest cases to reach are float lanes that sit on IEEE special values: mixed-sign zeros, NaNs on one side only, and infinities against denormals. Random bit patterns almost never produce these. The stimulus therefore builds each float lane from a weighted pick among these special encodings, with random values as the remainder, and copies some lanes from one operand to the other so that equal pairs occur. Signed and unsigned integer lanes are pushed to the sign boundary in the same way, with equal lanes forced by byte masks. A second behavioural model converts each single-precision lane to a double and compares the doubles, which gives an independent reference for the results.

// File: rtl/simd_cle_pkg.sv
package simd_cle_pkg;

    localparam int INSTR_W = 32;
    localparam int SLICE_W = 32;
    localparam int REG_IDX_W = 5;

    typedef enum logic [1:0] {
        LANE_B = 2'b00,
        LANE_H = 2'b01,
        LANE_W = 2'b10,
        LANE_X = 2'b11
    } lane_sz_e;

    typedef struct packed {
        lane_sz_e               lsz;
        logic                   uns;
        logic                   flt;
        logic                   vs_zero;
        logic                   quad;
        logic                   bad;
        logic [REG_IDX_W-1:0]   dest;
    } dec_t;

    function automatic logic f32_is_nan(input logic [31:0] v);
        return (v[30:23] == 8'hFF) && (v[22:0] != 23'd0);
    endfunction

    // IEEE single-precision a <= b on raw encodings
    function automatic logic f32_le(input logic [31:0] a, input logic [31:0] b);
        logic res;
        if (f32_is_nan(a) || f32_is_nan(b))
            res = 1'b0;
        else if ((a[30:0] == 31'd0) && (b[30:0] == 31'd0))
            res = 1'b1;
        else if (a[31] != b[31])
            res = a[31];
        else if (!a[31])
            res = (a[30:0] <= b[30:0]);
        else
            res = (a[30:0] >= b[30:0]);
        return res;
    endfunction

endpackage

// File: rtl/cle_decode.sv
module cle_decode
    import simd_cle_pkg::*;
(
    input  logic [INSTR_W-1:0] instr_i,
    output dec_t               dec_o
);
    logic hit_int, hit_flt, hit_zero, odd_reg, bad_size;
    logic [1:0] size_code;

    assign hit_int  = (instr_i[31:25] == 7'b1111001) && !instr_i[23]
                    && (instr_i[11:8] == 4'b0011) && instr_i[4];
    assign hit_flt  = (instr_i[31:23] == 9'b111100110) && !instr_i[21]
                    && (instr_i[11:8] == 4'b1110) && !instr_i[4];
    assign hit_zero = (instr_i[31:23] == 9'b111100111) && (instr_i[21:20] == 2'b11)
                    && (instr_i[17:16] == 2'b01) && !instr_i[11]
                    && (instr_i[9:7] == 3'b011) && !instr_i[4];

    always_comb begin
        if (hit_flt)
            size_code = 2'b10;
        else if (hit_zero)
            size_code = instr_i[19:18];
        else
            size_code = instr_i[21:20];
    end

    // quad register pairs must start on an even number
    assign odd_reg  = instr_i[6] && (instr_i[12] || instr_i[0]
                    || (!hit_zero && instr_i[16]));
    assign bad_size = (size_code == 2'b11)
                    || (hit_flt && instr_i[20])
                    || (hit_zero && instr_i[10] && (size_code != 2'b10));

    always_comb begin
        dec_o.lsz     = lane_sz_e'(size_code);
        dec_o.uns     = hit_int && instr_i[24];
        dec_o.flt     = hit_flt || (hit_zero && instr_i[10]);
        dec_o.vs_zero = hit_zero;
        dec_o.quad    = instr_i[6];
        dec_o.bad     = !(hit_int || hit_flt || hit_zero) || bad_size || odd_reg;
        dec_o.dest    = instr_i[6] ? {1'b0, instr_i[22], instr_i[15:13]}
                                   : {instr_i[22], instr_i[15:12]};
    end
endmodule

// File: rtl/cle_slice_cmp.sv
module cle_slice_cmp
    import simd_cle_pkg::*;
#(
    parameter int W = SLICE_W
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  lane_sz_e     lsz_i,
    input  logic         uns_i,
    input  logic         flt_i,
    output logic [W-1:0] mask_o
);
    localparam int NB = W / 8;
    localparam int NH = W / 16;

    logic [W-1:0] m_b, m_h;
    logic         le_w, le_f;

    // signed order = unsigned order with the sign bit inverted
    for (genvar k = 0; k < NB; k++) begin : g_byte
        logic le;
        assign le = {a_i[8*k+7] ^ ~uns_i, a_i[8*k +: 7]}
                 <= {b_i[8*k+7] ^ ~uns_i, b_i[8*k +: 7]};
        assign m_b[8*k +: 8] = {8{le}};
    end

    for (genvar k = 0; k < NH; k++) begin : g_half
        logic le;
        assign le = {a_i[16*k+15] ^ ~uns_i, a_i[16*k +: 15]}
                 <= {b_i[16*k+15] ^ ~uns_i, b_i[16*k +: 15]};
        assign m_h[16*k +: 16] = {16{le}};
    end

    assign le_w = {a_i[31] ^ ~uns_i, a_i[30:0]} <= {b_i[31] ^ ~uns_i, b_i[30:0]};
    assign le_f = f32_le(a_i[31:0], b_i[31:0]);

    always_comb begin
        case (lsz_i)
            LANE_B:  mask_o = m_b;
            LANE_H:  mask_o = m_h;
            LANE_W:  mask_o = {W{flt_i ? le_f : le_w}};
            default: mask_o = '0;
        endcase
    end
endmodule

// File: rtl/cle_vec_array.sv
module cle_vec_array
    import simd_cle_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic [VEC_W-1:0] a_i,
    input  logic [VEC_W-1:0] b_i,
    input  lane_sz_e         lsz_i,
    input  logic             uns_i,
    input  logic             flt_i,
    input  logic             quad_i,
    output logic [VEC_W-1:0] mask_o
);
    localparam int NSLICE = VEC_W / SLICE_W;
    localparam int HALF   = NSLICE / 2;

    for (genvar s = 0; s < NSLICE; s++) begin : g_slice
        localparam bit UPPER = (s >= HALF);
        logic [SLICE_W-1:0] raw;

        cle_slice_cmp #(.W(SLICE_W)) u_cmp (
            .a_i    (a_i[s*SLICE_W +: SLICE_W]),
            .b_i    (b_i[s*SLICE_W +: SLICE_W]),
            .lsz_i  (lsz_i),
            .uns_i  (uns_i),
            .flt_i  (flt_i),
            .mask_o (raw)
        );

        assign mask_o[s*SLICE_W +: SLICE_W] = (UPPER && !quad_i) ? '0 : raw;
    end
endmodule

// File: rtl/simd_cle_unit.sv
module simd_cle_unit
    import simd_cle_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 valid_in,
    input  logic [INSTR_W-1:0]   instr_in,
    input  logic [VEC_W-1:0]     opa_in,
    input  logic [VEC_W-1:0]     opb_in,
    output logic                 wr_en_o,
    output logic                 undef_o,
    output logic [REG_IDX_W-1:0] dest_o,
    output logic [VEC_W-1:0]     result_o
);
    localparam int HALF_W = VEC_W / 2;

    logic               valid_q;
    logic [INSTR_W-1:0] instr_q;
    logic [VEC_W-1:0]   opa_q, opb_q, lhs, rhs, mask;
    dec_t               dec;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            instr_q <= '0;
            opa_q   <= '0;
            opb_q   <= '0;
        end else begin
            valid_q <= valid_in;
            if (valid_in) begin
                instr_q <= instr_in;
                opa_q   <= opa_in;
                opb_q   <= opb_in;
            end
        end
    end

    cle_decode u_dec (
        .instr_i (instr_q),
        .dec_o   (dec)
    );

    // zero form: tested operand moves to the left side, right side is zero
    assign lhs = dec.vs_zero ? opb_q : opa_q;
    assign rhs = dec.vs_zero ? '0    : opb_q;

    cle_vec_array #(.VEC_W(VEC_W)) u_arr (
        .a_i    (lhs),
        .b_i    (rhs),
        .lsz_i  (dec.lsz),
        .uns_i  (dec.uns),
        .flt_i  (dec.flt),
        .quad_i (dec.quad),
        .mask_o (mask)
    );

    assign wr_en_o  = valid_q && !dec.bad;
    assign undef_o  = valid_q && dec.bad;
    assign dest_o   = dec.dest;
    assign result_o = dec.bad ? '0 : mask;

    p_we_after_valid_r8: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |-> $past(valid_in));
    p_undef_after_valid_r8: assert property (@(posedge clk) disable iff (rst)
        undef_o |-> $past(valid_in));
    p_flags_exclusive_r7: assert property (@(posedge clk) disable iff (rst)
        !(wr_en_o && undef_o));
    p_undef_clear_result_r7: assert property (@(posedge clk) disable iff (rst)
        undef_o |-> (result_o == '0));
    p_upper_idle_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en_o && !instr_q[6]) |-> (result_o[VEC_W-1:HALF_W] == '0));
    p_quiet_in_reset_r10: assert property (@(posedge clk)
        rst |=> (!wr_en_o && !undef_o));

    for (genvar k = 0; k < VEC_W / 8; k++) begin : g_chk
        p_byte_uniform_r1: assert property (@(posedge clk) disable iff (rst)
            wr_en_o |-> (result_o[8*k +: 8] == 8'h00 || result_o[8*k +: 8] == 8'hFF));
    end
endmodule

// File: tb/sim_simd_cle_unit.sv
module sim_simd_cle_unit;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         valid_in = 1'b0;
    logic [31:0]  instr_in = '0;
    logic [127:0] opa_in = '0, opb_in = '0;
    logic         wr_en_o, undef_o;
    logic [4:0]   dest_o;
    logic [127:0] result_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    simd_cle_unit #(.VEC_W(128)) u0 (
        .clk(clk), .rst(rst), .valid_in(valid_in), .instr_in(instr_in),
        .opa_in(opa_in), .opb_in(opb_in), .wr_en_o(wr_en_o), .undef_o(undef_o),
        .dest_o(dest_o), .result_o(result_o)
    );

    function automatic logic [31:0] mk_int(input logic u, input logic [1:0] sz, input logic q,
                                           input logic [4:0] rd, input logic [4:0] rn, input logic [4:0] rm);
        return {7'b1111001, u, 1'b0, rd[4], sz, rn[3:0], rd[3:0], 4'b0011, rn[4], q, rm[4], 1'b1, rm[3:0]};
    endfunction

    function automatic logic [31:0] mk_flt(input logic sz, input logic q,
                                           input logic [4:0] rd, input logic [4:0] rn, input logic [4:0] rm);
        return {7'b1111001, 1'b1, 1'b0, rd[4], 1'b0, sz, rn[3:0], rd[3:0], 4'b1110, rn[4], q, rm[4], 1'b0, rm[3:0]};
    endfunction

    function automatic logic [31:0] mk_zero(input logic [1:0] sz, input logic f, input logic q,
                                            input logic [4:0] rd, input logic [4:0] rm);
        return {9'b111100111, rd[4], 2'b11, sz, 2'b01, rd[3:0], 1'b0, f, 3'b011, q, rm[4], 1'b0, rm[3:0]};
    endfunction

    function automatic real f2r(input logic [31:0] v);
        real r;
        if (v[30:23] == 8'h00) begin
            r = real'(v[22:0]) * (2.0 ** -149);
            if (v[31]) r = -r;
        end else if (v[30:23] == 8'hFF)
            r = $bitstoreal({v[31], 11'h7FF, v[22:0], 29'd0});
        else
            r = $bitstoreal({v[31], 11'(v[30:23]) + 11'd896, v[22:0], 29'd0});
        return r;
    endfunction

    // behavioural per-lane model written from the requirements
    function automatic void model(input logic [31:0] ins, input logic [127:0] a, input logic [127:0] b,
                                  output logic bad, output logic [4:0] dst, output logic [127:0] res);
        int form, w, nl;
        logic uns, fl, q;
        logic [1:0] sz;
        logic [127:0] x, y;
        form = 0; uns = 0; fl = 0; bad = 0; q = ins[6];
        sz = ins[21:20]; x = a; y = b;
        if (ins[31:25] == 7'b1111001 && !ins[23] && ins[11:8] == 4'b0011 && ins[4]) begin
            form = 1; uns = ins[24];
        end else if (ins[31:23] == 9'b111100110 && !ins[21] && ins[11:8] == 4'b1110 && !ins[4]) begin
            form = 2; fl = 1; sz = 2'b10; bad = ins[20];
        end else if (ins[31:23] == 9'b111100111 && ins[21:20] == 2'b11 && ins[17:16] == 2'b01
                     && !ins[11] && ins[9:7] == 3'b011 && !ins[4]) begin
            form = 3; fl = ins[10]; sz = ins[19:18]; x = b; y = '0;
            if (fl && sz != 2'b10) bad = 1;
        end
        if (form == 0 || sz == 2'b11) bad = 1;
        if (q && (ins[12] || ins[0] || (form != 3 && ins[16]))) bad = 1;
        dst = q ? {1'b0, ins[22], ins[15:13]} : {ins[22], ins[15:12]};
        res = '0;
        if (!bad) begin
            w  = 8 << sz;
            nl = (q ? 128 : 64) / w;
            for (int i = 0; i < nl; i++) begin
                logic [63:0] ua, ub;
                longint sa, sb;
                logic le;
                ua = 64'(x >> (i * w)) & ((64'd1 << w) - 64'd1);
                ub = 64'(y >> (i * w)) & ((64'd1 << w) - 64'd1);
                if (fl)
                    le = (f2r(ua[31:0]) <= f2r(ub[31:0]));
                else if (uns)
                    le = (ua <= ub);
                else begin
                    sa = longint'(ua);
                    sb = longint'(ub);
                    if (ua[w-1]) sa = sa - longint'(64'd1 << w);
                    if (ub[w-1]) sb = sb - longint'(64'd1 << w);
                    le = (sa <= sb);
                end
                if (le) res = res | (((128'd1 << w) - 128'd1) << (i * w));
            end
        end
    endfunction

    task automatic chk(input string tag, input logic [127:0] got, input logic [127:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic run(input string tag, input logic [31:0] ins, input logic [127:0] a,
                       input logic [127:0] b, input bit use_tbl, input logic [127:0] t_res,
                       input logic t_bad);
        logic bad;
        logic [4:0] dst;
        logic [127:0] res;
        model(ins, a, b, bad, dst, res);
        if (use_tbl) begin
            res = t_res;
            bad = t_bad;
        end
        @(negedge clk);
        valid_in = 1'b1; instr_in = ins; opa_in = a; opb_in = b;
        @(negedge clk);
        valid_in = 1'b0;
        chk({tag, " R8 R7 flags"}, {126'd0, wr_en_o, undef_o}, {126'd0, !bad, bad});
        chk({tag, " R1 result"}, result_o, res);
        if (!bad) chk({tag, " R9 dest"}, {123'd0, dest_o}, {123'd0, dst});
        @(negedge clk);
        chk({tag, " R8 idle"}, {126'd0, wr_en_o, undef_o}, 128'd0);
    endtask

    typedef struct packed {
        logic [31:0]  ins;
        logic [127:0] a;
        logic [127:0] b;
        logic [127:0] exp;
        logic         bad;
    } vec_t;

    localparam int NTBL = 10;
    localparam logic [4:0] RD = 5'd2, RN = 5'd4, RM = 5'd6;
    localparam vec_t TBL [NTBL] = '{
        '{mk_int(1'b0, 2'b00, 1'b1, RD, RN, RM), {16{8'h80}}, {16{8'h7F}}, {128{1'b1}}, 1'b0},
        '{mk_int(1'b1, 2'b00, 1'b1, RD, RN, RM), {16{8'h80}}, {16{8'h7F}}, 128'd0, 1'b0},
        '{mk_int(1'b0, 2'b01, 1'b1, RD, RN, RM), {8{16'h0005}}, {8{16'h0005}}, {128{1'b1}}, 1'b0},
        '{mk_int(1'b0, 2'b10, 1'b1, RD, RN, RM), {4{32'h1}}, {4{32'hFFFF_FFFF}}, 128'd0, 1'b0},
        '{mk_int(1'b1, 2'b10, 1'b0, RD, RN, RM), {4{32'h1}}, {4{32'hFFFF_FFFF}},
          {64'd0, 64'hFFFF_FFFF_FFFF_FFFF}, 1'b0},
        '{mk_flt(1'b0, 1'b1, RD, RN, RM), {4{32'h8000_0000}}, {4{32'h0}}, {128{1'b1}}, 1'b0},
        '{mk_flt(1'b0, 1'b1, RD, RN, RM), {4{32'h7FC0_0000}}, {4{32'h7FC0_0000}}, 128'd0, 1'b0},
        '{mk_zero(2'b00, 1'b0, 1'b1, RD, RM), {128{1'b1}}, 128'd0, {128{1'b1}}, 1'b0},
        '{mk_zero(2'b10, 1'b1, 1'b1, RD, RM), 128'd0,
          {32'hBF80_0000, 32'h3F80_0000, 32'h8000_0000, 32'h7F80_0001},
          {32'hFFFF_FFFF, 32'h0, 32'hFFFF_FFFF, 32'h0}, 1'b0},
        '{mk_int(1'b0, 2'b11, 1'b1, RD, RN, RM), {128{1'b1}}, 128'd0, 128'd0, 1'b1}
    };

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    function automatic logic [31:0] rnd_f32();
        logic [31:0] v;
        case ($urandom % 10)
            0: v = 32'h0000_0000;
            1: v = 32'h8000_0000;
            2: v = 32'h7FC0_0000;
            3: v = 32'hFF80_0001;
            4: v = 32'h7F80_0000;
            5: v = 32'hFF80_0000;
            6: v = {$urandom % 2 == 0, 8'h00, 23'($urandom)};
            default: v = $urandom;
        endcase
        return v;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired R8 got=hung exp=finish");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [127:0] a, b, msk;
        // R10: quiet during reset even with a valid word presented
        valid_in = 1'b1;
        instr_in = mk_int(1'b0, 2'b00, 1'b1, RD, RN, RM);
        repeat (3) @(negedge clk);
        chk("R10 reset flags", {126'd0, wr_en_o, undef_o}, 128'd0);
        rst = 1'b0;
        valid_in = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R10 after reset", {126'd0, wr_en_o, undef_o}, 128'd0);

        // table walk: R1 R2 R3 R4 R5 R6 R7 edge values
        for (int t = 0; t < NTBL; t++)
            run($sformatf("tbl%0d R1", t), TBL[t].ins, TBL[t].a, TBL[t].b, 1'b1, TBL[t].exp, TBL[t].bad);

        // R2 R5: integer lane widths, signedness and both vector widths
        for (int sz = 0; sz < 3; sz++)
            for (int u = 0; u < 2; u++)
                for (int q = 0; q < 2; q++)
                    for (int r = 0; r < 12; r++) begin
                        a = rnd128();
                        b = rnd128();
                        msk = rnd128();
                        if (r % 3 == 0) b = (a & msk) | (b & ~msk);
                        if (r % 4 == 1) a = a ^ {16{8'h80}} & msk;
                        run("R2 int", mk_int(u[0], sz[1:0], q[0], 5'(2 * r), 5'(2 * r + 4), 5'(30 - 2 * r)),
                            a, b, 1'b0, '0, 1'b0);
                    end

        // R3 R6: float register form with special values
        for (int r = 0; r < 40; r++) begin
            for (int k = 0; k < 4; k++) begin
                a[32*k +: 32] = rnd_f32();
                b[32*k +: 32] = ($urandom % 4 == 0) ? a[32*k +: 32] : rnd_f32();
            end
            run("R3 R6 flt", mk_flt(1'b0, r[0], 5'(2 * (r % 16)), 5'd8, 5'd10), a, b, 1'b0, '0, 1'b0);
        end

        // R4: zero forms, integer widths and float
        for (int sz = 0; sz < 3; sz++)
            for (int r = 0; r < 10; r++) begin
                b = rnd128();
                if (r % 3 == 0) b = b & rnd128() & rnd128();
                run("R4 zint", mk_zero(sz[1:0], 1'b0, r[0], 5'd12, 5'd20), rnd128(), b, 1'b0, '0, 1'b0);
            end
        for (int r = 0; r < 20; r++) begin
            for (int k = 0; k < 4; k++) b[32*k +: 32] = rnd_f32();
            run("R4 R6 zflt", mk_zero(2'b10, 1'b1, r[0], 5'd14, 5'd22), rnd128(), b, 1'b0, '0, 1'b0);
        end

        // R7: illegal words
        run("R7 flt sz", mk_flt(1'b1, 1'b1, RD, RN, RM), rnd128(), rnd128(), 1'b0, '0, 1'b0);
        run("R7 zflt size", mk_zero(2'b01, 1'b1, 1'b1, RD, RM), rnd128(), rnd128(), 1'b0, '0, 1'b0);
        run("R7 zero size3", mk_zero(2'b11, 1'b0, 1'b0, RD, RM), rnd128(), rnd128(), 1'b0, '0, 1'b0);
        run("R7 odd dest", mk_int(1'b0, 2'b00, 1'b1, 5'd3, RN, RM), rnd128(), rnd128(), 1'b0, '0, 1'b0);
        run("R7 odd src n", mk_flt(1'b0, 1'b1, RD, 5'd5, RM), rnd128(), rnd128(), 1'b0, '0, 1'b0);
        run("R7 odd src m", mk_zero(2'b00, 1'b0, 1'b1, RD, 5'd7), rnd128(), rnd128(), 1'b0, '0, 1'b0);
        run("R7 no match", 32'h0000_0000, rnd128(), rnd128(), 1'b0, '0, 1'b0);

        // R9 R5: odd registers are legal in 64-bit forms; high register bank
        run("R9 dword odd", mk_int(1'b1, 2'b01, 1'b0, 5'd19, 5'd21, 5'd23), rnd128(), rnd128(), 1'b0, '0, 1'b0);
        run("R9 quad high", mk_int(1'b0, 2'b10, 1'b1, 5'd30, 5'd16, 5'd18), rnd128(), rnd128(), 1'b0, '0, 1'b0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule